// File: doc/BRIEF.md
# Slow-Clock System Timer

This peripheral keeps time from a 32768 Hz slow clock and is read and programmed over a simple synchronous register bus in a faster system-clock domain. A free-running counter advances once every N slow-clock ticks, where N comes from a programmable divider. An absolute alarm compares against that counter. A periodic tick generator raises an event every M slow-clock ticks and restarts by itself.

Every event lands in a sticky status register that a bus read returns and clears in one access. A combined interrupt line is raised while any pending status bit is also enabled. Enables are set and cleared through two separate write-only registers, so software never needs a read-modify-write.

The slow clock is not used as a clock at all. It is oversampled by a synchronizer in the system domain and turned into a one-cycle tick strobe. As a result, all timer state lives in the bus domain and every counter read returns a value that was really held.

Top module: `slow_timer`

## Requirements
- R1: After reset the counter, alarm value, period, status and enable mask all read 0, the divider register reads its reset parameter value, and the interrupt is low.
- R2: With divider value N (0 meaning 2^PRE_W), the counter advances once every N rising edges of the slow clock. Writing the divider register (word offset 0) clears the counter and restarts the division.
- R3: The counter (word offset 3) wraps from all ones to zero.
- R4: Status bit 2 sets on every counter advance.
- R5: Status bit 3 sets when the counter becomes equal to the alarm value (word offset 2). An alarm value equal to the current count therefore matches only after a full wrap of 2^CNT_W advances.
- R6: With period M (word offset 1, 0 meaning 2^PIT_W), status bit 0 sets on every M-th slow-clock rising edge and the count restarts by itself. Writing the period restarts it.
- R7: A one-cycle pulse on `wdog_ovf` sets status bit 1.
- R8: Reading status (word offset 4) returns the pending bits and clears them all. An event arriving in the same cycle as that read stays pending.
- R9: Writing ones to offset 5 sets those enable bits and writing ones to offset 6 clears them. Zero bits leave an enable unchanged, and the mask reads back at offset 7.
- R10: `irq` is high exactly while some status bit and its enable are both set. It falls in the cycle after a status read clears the active bits.
- R11: Successive counter values seen on the bus step by at most one (or wrap, or reset on a divider write), never backwards.
- R12: Writes to offsets 3, 4 and 7 change nothing. Reads of offsets 5 and 6 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System/bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | 32768 Hz slow clock, asynchronous |
| wdog_ovf | input | 1 | Watchdog overflow event pulse, bus domain |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| irq | output | 1 | Combined interrupt |

## Verification
The bench shrinks the counter to eight bits so that it can drive the alarm through a full wrap. If the alarm compared against the current count instead of the next one, it would fire at once rather than 256 advances later. It sweeps every small divider and period value, including zero as the largest setting, which catches off-by-one dividers and a zero that stalls the timer. It also lands a watchdog event in the exact cycle of a status read; a design that cleared after setting would silently drop that event.

// File: rtl/slow_timer_pkg.sv
package slow_timer_pkg;
  localparam int ADDR_W = 3;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t ADR_MODE  = 3'd0;
  localparam addr_t ADR_PER   = 3'd1;
  localparam addr_t ADR_ALARM = 3'd2;
  localparam addr_t ADR_CNT   = 3'd3;
  localparam addr_t ADR_STS   = 3'd4;
  localparam addr_t ADR_IEN_S = 3'd5;
  localparam addr_t ADR_IEN_C = 3'd6;
  localparam addr_t ADR_MASK  = 3'd7;

  localparam int ST_W    = 4;
  localparam int SB_PIT  = 0;
  localparam int SB_WDOG = 1;
  localparam int SB_INC  = 2;
  localparam int SB_ALM  = 3;
endpackage

// File: rtl/st_edge_sync.sv
module st_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], async_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/st_rtc.sv
module st_rtc #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pre_wr_i,
  input  logic [PRE_W-1:0] pre_wdata_i,
  output logic [PRE_W-1:0] pre_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inc_o
);
  logic [PRE_W-1:0] pre_q, pre_d, div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en, div_end;

  assign div_end = (div_q == PRE_W'(pre_q - 1'b1));
  assign en      = pre_wr_i | tick_i;

  always_comb begin
    pre_d = pre_q;
    div_d = div_q;
    cnt_d = cnt_q;
    inc_o = 1'b0;
    if (pre_wr_i) begin
      pre_d = pre_wdata_i;
      div_d = '0;
      cnt_d = '0;
    end else if (tick_i) begin
      if (div_end) begin
        div_d = '0;
        cnt_d = CNT_W'(cnt_q + 1'b1);
        inc_o = 1'b1;
      end else begin
        div_d = PRE_W'(div_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= PRE_W'(PRE_RST);
      div_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      pre_q <= pre_d;
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign pre_o = pre_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/st_pit.sv
module st_pit #(
  parameter int PIT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             per_wr_i,
  input  logic [PIT_W-1:0] per_wdata_i,
  output logic [PIT_W-1:0] per_o,
  output logic             fire_o
);
  logic [PIT_W-1:0] per_q, per_d, pc_q, pc_d;
  logic             en, pc_end;

  assign pc_end = (pc_q == PIT_W'(per_q - 1'b1));
  assign en     = per_wr_i | tick_i;

  always_comb begin
    per_d  = per_q;
    pc_d   = pc_q;
    fire_o = 1'b0;
    if (per_wr_i) begin
      per_d = per_wdata_i;
      pc_d  = '0;
    end else if (tick_i) begin
      if (pc_end) begin
        pc_d   = '0;
        fire_o = 1'b1;
      end else begin
        pc_d = PIT_W'(pc_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      pc_q  <= '0;
    end else if (en) begin
      per_q <= per_d;
      pc_q  <= pc_d;
    end
  end

  assign per_o = per_q;
endmodule

// File: rtl/slow_timer.sv
module slow_timer
  import slow_timer_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int PRE_W       = 16,
  parameter int PIT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_RST     = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              wdog_ovf,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0]       rs_q;
  logic             rst_q_n;
  logic             tick_w, inc_w, pit_fire;
  logic [PRE_W-1:0] pre_w;
  logic [PIT_W-1:0] per_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] alarm_q, alarm_d;
  logic [ST_W-1:0]  sts_q, sts_d, ien_q, ien_d, ev_w;
  logic             wr_hit, rd_hit, mode_wr, per_wr, alm_wr;
  logic             ien_set_wr, ien_clr_wr, rd_sts, alm_hit;
  logic             sts_en, ien_en;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  assign wr_hit     = bus_sel & bus_wr;
  assign rd_hit     = bus_sel & ~bus_wr;
  assign mode_wr    = wr_hit & (bus_addr == ADR_MODE);
  assign per_wr     = wr_hit & (bus_addr == ADR_PER);
  assign alm_wr     = wr_hit & (bus_addr == ADR_ALARM);
  assign ien_set_wr = wr_hit & (bus_addr == ADR_IEN_S);
  assign ien_clr_wr = wr_hit & (bus_addr == ADR_IEN_C);
  assign rd_sts     = rd_hit & (bus_addr == ADR_STS);

  st_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .async_i(slow_clk), .rise_o(tick_w)
  );

  st_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
    .clk(clk), .rst_n(rst_q_n), .tick_i(tick_w), .pre_wr_i(mode_wr),
    .pre_wdata_i(bus_wdata[PRE_W-1:0]), .pre_o(pre_w), .cnt_o(cnt_w),
    .inc_o(inc_w)
  );

  st_pit #(.PIT_W(PIT_W)) u_pit (
    .clk(clk), .rst_n(rst_q_n), .tick_i(tick_w), .per_wr_i(per_wr),
    .per_wdata_i(bus_wdata[PIT_W-1:0]), .per_o(per_w), .fire_o(pit_fire)
  );

  assign alm_hit = inc_w & (CNT_W'(cnt_w + 1'b1) == alarm_q);

  always_comb begin
    ev_w          = '0;
    ev_w[SB_PIT]  = pit_fire;
    ev_w[SB_WDOG] = wdog_ovf;
    ev_w[SB_INC]  = inc_w;
    ev_w[SB_ALM]  = alm_hit;
  end

  // Clear first, then merge new events so a same-cycle event survives.
  always_comb begin
    sts_d   = (rd_sts ? '0 : sts_q) | ev_w;
    sts_en  = rd_sts | (|ev_w);
    ien_d   = ien_q;
    if (ien_set_wr) ien_d = ien_q | bus_wdata[ST_W-1:0];
    if (ien_clr_wr) ien_d = ien_q & ~bus_wdata[ST_W-1:0];
    ien_en  = ien_set_wr | ien_clr_wr;
    alarm_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sts_q   <= '0;
      ien_q   <= '0;
      alarm_q <= '0;
    end else begin
      if (sts_en) sts_q   <= sts_d;
      if (ien_en) ien_q   <= ien_d;
      if (alm_wr) alarm_q <= alarm_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (bus_addr)
        ADR_MODE:  bus_rdata = DATA_W'(pre_w);
        ADR_PER:   bus_rdata = DATA_W'(per_w);
        ADR_ALARM: bus_rdata = DATA_W'(alarm_q);
        ADR_CNT:   bus_rdata = DATA_W'(cnt_w);
        ADR_STS:   bus_rdata = DATA_W'(sts_q);
        ADR_MASK:  bus_rdata = DATA_W'(ien_q);
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/slow_timer_chk.sv
module slow_timer_chk #(
  parameter int CNT_W = 20,
  parameter int ST_W  = 4,
  parameter int ALM_B = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             inc,
  input logic             mode_wr,
  input logic [CNT_W-1:0] alarm,
  input logic [ST_W-1:0]  sts,
  input logic [ST_W-1:0]  ev,
  input logic             rd_sts,
  input logic             ien_set_wr,
  input logic [ST_W-1:0]  ien,
  input logic [ST_W-1:0]  set_bits
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !mode_wr) |=> $stable(cnt));

  p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !mode_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !mode_wr && (cnt == '1)) |=> (cnt == '0));

  p_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (CNT_W'(cnt + 1'b1) == alarm)) |=> sts[ALM_B]);

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((sts & $past(ev)) == $past(ev)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && (ev == '0)) |=> (sts == '0));

  p_ienset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ien_set_wr |=> ((ien & $past(set_bits)) == $past(set_bits)));
endmodule

bind slow_timer slow_timer_chk #(
  .CNT_W(CNT_W), .ST_W(slow_timer_pkg::ST_W), .ALM_B(slow_timer_pkg::SB_ALM)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .cnt(cnt_w), .inc(inc_w), .mode_wr(mode_wr),
  .alarm(alarm_q), .sts(sts_q), .ev(ev_w), .rd_sts(rd_sts),
  .ien_set_wr(ien_set_wr), .ien(ien_q), .set_bits(bus_wdata[slow_timer_pkg::ST_W-1:0])
);

// File: tb/slow_timer_test.sv
module slow_timer_test;
  localparam int CW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_clk = 1'b0;
  logic          wdog_ovf = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  slow_timer #(.CNT_W(CW), .PRE_W(4), .PIT_W(4), .DATA_W(DW), .SYNC_STAGES(2),
               .PRE_RST(9)) uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wdog_ovf(wdog_ovf),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic slow_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_clk = 1'b1;
      repeat (3) @(negedge clk);
      slow_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic wdog_pulse();
    @(negedge clk); wdog_ovf = 1'b1;
    @(negedge clk); wdog_ovf = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int bad;
    int model;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    rd(3'd0, d); chk("R1 divider", d, 9);
    rd(3'd1, d); chk("R1 period", d, 0);
    rd(3'd2, d); chk("R1 alarm", d, 0);
    rd(3'd3, d); chk("R1 count", d, 0);
    rd(3'd4, d); chk("R1 status", d, 0);
    rd(3'd7, d); chk("R1 mask", d, 0);

    // R12 read-only / write-only offsets
    wr(3'd3, 32'h55); wr(3'd7, 32'hF); wr(3'd4, 32'hF);
    rd(3'd3, d); chk("R12 count unchanged", d, 0);
    rd(3'd7, d); chk("R12 mask unchanged", d, 0);
    rd(3'd4, d); chk("R12 status unchanged", d, 0);
    rd(3'd5, d); chk("R12 set reg reads 0", d, 0);
    rd(3'd6, d); chk("R12 clr reg reads 0", d, 0);

    // R2 divider sweep, 0 means 16
    for (int p = 0; p < 6; p++) begin
      int eff;
      eff = (p == 0) ? 16 : p;
      wr(3'd0, p);
      rd(3'd3, d); chk("R2 cleared on divider write", d, 0);
      bad = 0;
      for (int k = 1; k <= 2 * eff + 1; k++) begin
        slow_ticks(1);
        rd(3'd3, d);
        if (d !== (k / eff)) begin
          bad++;
          $display("FAIL R2 div=%0d tick=%0d actual=%0h expected=%0h", p, k, d, k / eff);
        end
      end
      checks++;
      if (bad != 0) errors++;
    end

    // R4 increment flag, R8 clear
    wr(3'd0, 1);
    rd(3'd4, d);
    slow_ticks(1);
    rd(3'd4, d); chk("R4 inc flag", d & 4, 4);
    rd(3'd4, d); chk("R8 cleared by read", d & 4, 0);

    // R3 / R11 wrap and monotonic stepping
    model = 1;
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      slow_ticks(1);
      model = (model + 1) % 256;
      rd(3'd3, d);
      if (d !== model) begin
        bad++;
        $display("FAIL R3/R11 step=%0d actual=%0h expected=%0h", k, d, model);
      end
    end
    checks++;
    if (bad != 0) errors++;
    chk("R3 wrapped value", d, (301 % 256));

    // R6 periodic sweep, 0 means 16
    for (int m = 0; m < 5; m++) begin
      int eff;
      eff = (m == 0) ? 16 : m;
      wr(3'd1, m);
      rd(3'd4, d);
      bad = 0;
      for (int t = 1; t <= 2 * eff + 1; t++) begin
        slow_ticks(1);
        rd(3'd4, d);
        if ((d & 1) !== ((t % eff) == 0 ? 1 : 0)) begin
          bad++;
          $display("FAIL R6 period=%0d tick=%0d actual=%0h expected=%0h",
                   m, t, d & 1, (t % eff) == 0);
        end
      end
      checks++;
      if (bad != 0) errors++;
    end

    // R7 watchdog flag
    rd(3'd4, d);
    wdog_pulse();
    rd(3'd4, d); chk("R7 wdog flag", d & 2, 2);

    // R5 alarm match
    wr(3'd0, 1);
    wr(3'd2, 5);
    rd(3'd2, d); chk("R5 alarm readback", d, 5);
    rd(3'd4, d);
    slow_ticks(4);
    rd(3'd4, d); chk("R5 no match before", d & 8, 0);
    slow_ticks(1);
    rd(3'd4, d); chk("R5 match at alarm", d & 8, 8);

    // R9 enable set/clear
    wr(3'd5, 5);  rd(3'd7, d); chk("R9 set 0101", d, 5);
    wr(3'd5, 2);  rd(3'd7, d); chk("R9 set 0010", d, 7);
    wr(3'd6, 4);  rd(3'd7, d); chk("R9 clr 0100", d, 3);
    wr(3'd6, 0);  rd(3'd7, d); chk("R9 clr zero", d, 3);

    // R5 deferred by full wrap, observed on irq
    wr(3'd6, 32'hF);
    wr(3'd5, 8);
    wr(3'd2, 5);
    rd(3'd4, d);
    bad = 0;
    for (int k = 0; k < 255; k++) begin
      slow_ticks(1);
      if (irq !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R5 early alarm actual=%0d expected=0", bad);
    end
    slow_ticks(1);
    chk("R5 alarm after wrap", {31'd0, irq}, 1);

    // R10 drop after clearing read
    rd(3'd4, d);
    chk("R10 irq drops after read", {31'd0, irq}, 0);
    wr(3'd6, 32'hF);
    wr(3'd5, 2);
    wdog_pulse();
    chk("R10 irq on enabled event", {31'd0, irq}, 1);
    wr(3'd6, 2);
    chk("R10 irq off when disabled", {31'd0, irq}, 0);

    // R8 event in the same cycle as the status read
    rd(3'd4, d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd4; wdog_ovf = 1'b1;
    #1 chk("R8 read before event", bus_rdata & 2, 0);
    @(negedge clk);
    bus_sel = 1'b0; wdog_ovf = 1'b0;
    rd(3'd4, d); chk("R8 same-cycle event kept", d & 2, 2);

    summary();
    $finish;
  end
endmodule